// File: doc/BRIEF.md
# Pipelined 16-bit SPI Register Slave

This block is a slave-only SPI front end that gives an external master read and write access to a small internal register file. Every transaction is a fixed frame of 16 serial clocks. The serial clock, the active-low select and the serial data input are brought in through synchronizers and oversampled with a fast system clock. Receive data is captured on falling serial-clock edges. Transmit data changes on rising edges. Each complete frame is decoded only after select returns high. For that reason the answer to a command leaves the block in the frame that follows it, not in the frame that carried it.

A command word is followed by a data word when it requests a write. A reserved address and key pair forms a software reset. That reset clears the registers and the response pipeline, and it samples the wire-mode pin again. The wire-mode pin is latched during power-on reset. High selects 4-wire operation, with a separate input and output line. Low selects 3-wire operation: the single data line is driven only in frames that carry a response, and in every other frame it is left to the master.

Top module: `spi_regslave`

## Requirements
- R1: While `rst` is high, the wire mode is loaded from `mode_4w_i` and every register and the pending response are cleared. After reset, `spi_dout_en_o` is low and the first response shifted out is all zeros.
- R2: A frame shifts its word MSB first. The input is sampled on falling `spi_clk_i` edges and the output changes on rising edges. A frame is complete only when select returns high after exactly 16 clocks, and a write followed by a read of the same register returns the written 15-bit value.
- R3: The command format is: bit 15 = read (1) or write (0), bits 14:1 = register address, bit 0 = XOR of bits 15:1. A read in frame N returns `{1'b0, data}` in frame N+1, and frames can be chained back to back.
- R4: A command whose bit 0 differs from the XOR of bits 15:1 is ignored. The next frame returns 16'h8000 (error flag in bit 15). That next frame is then decoded as a command, not as write data.
- R5: A frame that ends with any count other than 16 clocks has no effect. A write command stays armed across an aborted data frame, and bits 14:0 of the next complete frame are committed.
- R6: Addresses at or above DEPTH (8) read as zero, and writes to them change no register.
- R7: In 3-wire mode, `spi_dout_en_o` is high only during a frame that follows a read command or a parity-failed command. During such a frame the input is ignored. The output enable is low whenever select is high, in either mode.
- R8: In 4-wire mode, `spi_dout_en_o` is high while select is low.
- R9: After reset, changes on `mode_4w_i` have no effect on the latched wire mode until a software reset.
- R10: Writing key 15'h2A55 to address 14'h3FFF clears all registers, the pending response and any armed write, and reloads the wire mode from `mode_4w_i`.
- R11: Serial-clock edges while select is high are ignored.
- R12: The frame after a write command, and the frame after a write data frame, return 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_4w_i | input | 1 | Wire-mode pin: 1 = 4-wire, 0 = 3-wire |
| spi_clk_i | input | 1 | Serial clock from the master |
| spi_sel_n_i | input | 1 | Active-low frame select from the master |
| spi_din_i | input | 1 | Serial data input (the input side of the shared line in 3-wire mode) |
| spi_dout_o | output | 1 | Serial data output |
| spi_dout_en_o | output | 1 | Output enable for the data output or the shared line |

## Verification
The bench goes after the one-frame latency by chaining reads across every register with two complementary data patterns. A design that answered in the same frame, or two frames late, returns the data of the wrong address. It also sends frames of 8 and 20 clocks between a write command and its data: a design that committed or disarmed on an aborted frame ends up with the wrong register contents. Parity failures are followed at once by a valid command, which catches a design that treats the next word as write data or drops the error flag. In 3-wire mode the response frame carries a well-formed write command on the input, and a design that decodes it corrupts the read that follows. Changes on the mode pin before and after a software reset show whether the wire mode is latched at the right moments.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 14;
  localparam int DATA_W  = FRAME_W - 1;

  typedef logic [FRAME_W-1:0] frame_t;

  // bit 0 must equal the XOR of the upper fifteen bits
  function automatic logic parity_ok(frame_t w);
    return (^w[FRAME_W-1:1]) == w[0];
  endfunction

  function automatic frame_t make_resp(logic err, logic [DATA_W-1:0] d);
    return {err, d};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[i]}};
      else     chain <= {chain[STAGES-2:0], d_in[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_regslave_pkg::*;
#(
  localparam int CNT_MAX = FRAME_W + 1,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             ssn,
  input  logic             sdi,
  input  frame_t           load_word,
  output frame_t           rx_word,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             frame_start,
  output logic             frame_done,
  output logic             sdo
);
  logic   sck_prev, ssn_prev;
  logic   sck_rise, sck_fall, ssn_rise;
  frame_t tx_shift;

  assign sck_rise    =  sck & ~sck_prev;
  assign sck_fall    = ~sck &  sck_prev;
  assign ssn_rise    =  ssn & ~ssn_prev;
  assign frame_start = ~ssn &  ssn_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev   <= 1'b0;
      ssn_prev   <= 1'b1;
      bit_cnt    <= '0;
      rx_word    <= '0;
      tx_shift   <= '0;
      sdo        <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      sck_prev   <= sck;
      ssn_prev   <= ssn;
      frame_done <= ssn_rise && (bit_cnt == CNT_W'(FRAME_W));
      if (frame_start) begin
        tx_shift <= load_word;
        bit_cnt  <= '0;
      end else if (!ssn) begin
        if (sck_fall) begin
          rx_word <= {rx_word[FRAME_W-2:0], sdi};
          if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sck_rise) begin
          sdo      <= tx_shift[FRAME_W-1];
          tx_shift <= {tx_shift[FRAME_W-2:0], 1'b0};
        end
      end else begin
        bit_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int  DEPTH  = 8,
  parameter int  DATA_W = 15,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clr)                   mem[i] <= '0;
      else if (we && waddr == AW'(i))   mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_regslave_pkg::*;
#(
  parameter int                DEPTH     = 8,
  parameter logic [ADDR_W-1:0] SRST_ADDR = '1,
  parameter logic [DATA_W-1:0] SRST_KEY  = 15'h2A55,
  localparam int               AW        = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pin,
  input  logic              frame_done,
  input  frame_t            rx_word,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output frame_t            tx_word,
  output logic              wmode,
  output logic              resp_pending,
  output logic              expect_data,
  output logic              srst
);
  logic [ADDR_W-1:0] wr_tgt;
  logic [ADDR_W-1:0] cmd_addr;
  logic              cmd_rd, cmd_in_range;
  logic              resp_slot, data_slot, cmd_slot;

  assign cmd_rd       = rx_word[FRAME_W-1];
  assign cmd_addr     = rx_word[ADDR_W:1];
  assign cmd_in_range = cmd_addr < ADDR_W'(DEPTH);

  // in 3-wire mode a response frame carries no command
  assign resp_slot = frame_done && resp_pending && !wmode;
  assign data_slot = frame_done && !resp_slot && expect_data;
  assign cmd_slot  = frame_done && !resp_slot && !expect_data;

  assign srst    = data_slot && (wr_tgt == SRST_ADDR) && (rx_word[DATA_W-1:0] == SRST_KEY);
  assign wr_en   = data_slot && (wr_tgt < ADDR_W'(DEPTH));
  assign wr_addr = wr_tgt[AW-1:0];
  assign wr_data = rx_word[DATA_W-1:0];
  assign rd_addr = cmd_addr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      wmode        <= mode_pin;
      tx_word      <= '0;
      resp_pending <= 1'b0;
      expect_data  <= 1'b0;
      wr_tgt       <= '0;
    end else if (resp_slot) begin
      tx_word      <= '0;
      resp_pending <= 1'b0;
    end else if (data_slot) begin
      tx_word      <= '0;
      expect_data  <= 1'b0;
    end else if (cmd_slot) begin
      if (!parity_ok(rx_word)) begin
        tx_word      <= make_resp(1'b1, '0);
        resp_pending <= 1'b1;
      end else if (cmd_rd) begin
        tx_word      <= make_resp(1'b0, cmd_in_range ? rd_data : '0);
        resp_pending <= 1'b1;
      end else begin
        tx_word      <= '0;
        resp_pending <= 1'b0;
        expect_data  <= 1'b1;
        wr_tgt       <= cmd_addr;
      end
    end
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int                DEPTH       = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SRST_ADDR   = '1,
  parameter logic [DATA_W-1:0] SRST_KEY    = 15'h2A55
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_4w_i,
  input  logic spi_clk_i,
  input  logic spi_sel_n_i,
  input  logic spi_din_i,
  output logic spi_dout_o,
  output logic spi_dout_en_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [2:0]        pin_q;
  logic              sck_s, ssn_s, sdi_s;
  frame_t            rx_word, tx_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              frame_start, frame_done;
  logic [AW-1:0]     rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, wmode, resp_pending, expect_data, srst;
  logic              cur_resp;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({spi_din_i, spi_sel_n_i, spi_clk_i}),
    .q    (pin_q)
  );
  assign sck_s = pin_q[0];
  assign ssn_s = pin_q[1];
  assign sdi_s = pin_q[2];

  spi_frame_shifter u_shift (
    .clk         (clk),
    .rst         (rst),
    .sck         (sck_s),
    .ssn         (ssn_s),
    .sdi         (sdi_s),
    .load_word   (tx_word),
    .rx_word     (rx_word),
    .bit_cnt     (bit_cnt),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .sdo         (spi_dout_o)
  );

  spi_cmd_engine #(.DEPTH(DEPTH), .SRST_ADDR(SRST_ADDR), .SRST_KEY(SRST_KEY)) u_engine (
    .clk          (clk),
    .rst          (rst),
    .mode_pin     (mode_4w_i),
    .frame_done   (frame_done),
    .rx_word      (rx_word),
    .rd_data      (rd_data),
    .rd_addr      (rd_addr),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .tx_word      (tx_word),
    .wmode        (wmode),
    .resp_pending (resp_pending),
    .expect_data  (expect_data),
    .srst         (srst)
  );

  spi_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .clr   (srst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // output enable: whole frame in 4-wire, response frames only in 3-wire
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_resp      <= 1'b0;
      spi_dout_en_o <= 1'b0;
    end else begin
      if (frame_start) cur_resp <= resp_pending;
      spi_dout_en_o <= ~ssn_s & (wmode | (frame_start ? resp_pending : cur_resp));
    end
  end
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_4w_i,
  input logic             spi_dout_en_o,
  input logic             ssn_s,
  input logic             wmode,
  input logic             srst,
  input logic             expect_data,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [15:0]      tx_word
);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ssn_s |=> !spi_dout_en_o);

  assert_four_wire_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (wmode && !ssn_s) |=> spi_dout_en_o);

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (rst)
    !srst |=> $stable(wmode));

  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (rst)
    srst |=> (wmode == $past(mode_4w_i)) && !expect_data && (tx_word == 16'h0));

  assert_idle_count_R11: assert property (@(posedge clk) disable iff (rst)
    ssn_s |=> (bit_cnt == '0));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(17));
endmodule

bind spi_regslave spi_regslave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_4w_i     (mode_4w_i),
  .spi_dout_en_o (spi_dout_en_o),
  .ssn_s         (ssn_s),
  .wmode         (wmode),
  .srst          (srst),
  .expect_data   (expect_data),
  .bit_cnt       (bit_cnt),
  .tx_word       (tx_word)
);

// File: tb/test_spi_regslave.sv
`timescale 1ns/1ps
module test_spi_regslave;
  localparam int HALF  = 8;
  localparam int GAP   = 12;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b1;
  logic sck = 1'b0;
  logic ssn = 1'b1;
  logic sdi = 1'b0;
  logic sdo, en;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;
  logic [14:0] model [DEPTH];
  logic [15:0] r;
  logic        e;

  always #2.5 clk = ~clk;

  spi_regslave i_spi_regslave (
    .clk           (clk),
    .rst           (rst),
    .mode_4w_i     (mode),
    .spi_clk_i     (sck),
    .spi_sel_n_i   (ssn),
    .spi_din_i     (sdi),
    .spi_dout_o    (sdo),
    .spi_dout_en_o (en)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cmd(input logic rd, input logic [13:0] a);
    logic [15:0] w;
    w = {rd, a, 1'b0};
    w[0] = ^w[15:1];
    return w;
  endfunction

  task automatic xfer(input logic [15:0] w, input int nclk, output logic [15:0] rr, output logic en_mid);
    rr = '0;
    en_mid = 1'b0;
    ssn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      sck = 1'b1;
      wait_clk(HALF);
      if (i < 16) rr[15-i] = sdo;
      if (i == 7) en_mid = en;
      sck = 1'b0;
      wait_clk(HALF);
    end
    ssn = 1'b1;
    wait_clk(GAP);
  endtask

  // write command plus data frame; responses of both frames must be zero (R12)
  task automatic wr(input logic [13:0] a, input logic [14:0] d, input bit chk_resp);
    xfer(mk_cmd(1'b0, a), 16, r, e);
    xfer({1'b0, d}, 16, r, e);
    if (chk_resp) check("R12 data frame response", r, 0);
    if (a < DEPTH) model[a] = d;
  endtask

  // chained reads in 4-wire mode: frame N+1 carries the answer to frame N (R3)
  task automatic sweep4(input string tag);
    xfer(mk_cmd(1'b1, 14'd0), 16, r, e);
    check({tag, " R8 enable"}, e, 1);
    for (int a = 1; a <= DEPTH; a++) begin
      xfer(mk_cmd(1'b1, 14'(a % DEPTH)), 16, r, e);
      check({tag, " R3 chained read"}, r, {1'b0, model[a-1]});
    end
  endtask

  // 3-wire read: command frame undriven, response frame driven (R7)
  task automatic read3(input logic [13:0] a, input logic [15:0] garbage, input logic [15:0] exp);
    xfer(mk_cmd(1'b1, a), 16, r, e);
    check("R7 command frame enable low", e, 0);
    xfer(garbage, 16, r, e);
    check("R7 response frame enable high", e, 1);
    check("R7 response data", r, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    wait_clk(10);
    check("R1 enable low in reset", en, 0);
    rst = 1'b0;
    wait_clk(5);
    check("R1 enable low after reset", en, 0);

    // R1: first response after reset is zero, registers read as zero
    xfer(mk_cmd(1'b1, 14'd5), 16, r, e);
    check("R1 first response zero", r, 0);
    sweep4("R1 reset contents");

    // R2: pattern A then its complement, every register
    for (int a = 0; a < DEPTH; a++) begin
      xfer(mk_cmd(1'b0, 14'(a)), 16, r, e);
      check("R12 write command response", r, 0);
      xfer({1'b0, 15'((a * 15'h1357 + 15'h00A5) & 15'h7FFF)}, 16, r, e);
      check("R12 data frame response", r, 0);
      model[a] = 15'((a * 15'h1357 + 15'h00A5) & 15'h7FFF);
    end
    sweep4("R2 pattern A");
    for (int a = 0; a < DEPTH; a++) wr(14'(a), ~model[a], 1'b1);
    sweep4("R2 pattern B");

    // R6: out-of-range addresses
    wr(14'd8, 15'h7777, 1'b1);
    wr(14'd100, 15'h1234, 1'b1);
    xfer(mk_cmd(1'b1, 14'd8), 16, r, e);
    xfer(mk_cmd(1'b1, 14'd0), 16, r, e);
    check("R6 out-of-range read zero", r, 0);
    sweep4("R6 no aliasing");

    // R4: parity failure
    xfer(mk_cmd(1'b0, 14'd1) ^ 16'h0001, 16, r, e);
    xfer(mk_cmd(1'b1, 14'd1), 16, r, e);
    check("R4 error flag response", r, 16'h8000);
    xfer(mk_cmd(1'b1, 14'd0), 16, r, e);
    check("R4 next frame decoded as command", r, {1'b0, model[1]});

    // R5: aborted frames (short and long) do not commit
    xfer(mk_cmd(1'b0, 14'd2), 16, r, e);
    xfer(16'h1111, 8, r, e);
    xfer(16'h2222, 16, r, e);
    model[2] = 15'h2222;
    xfer(mk_cmd(1'b0, 14'd3), 16, r, e);
    xfer(16'h3333, 20, r, e);
    xfer(16'h4444, 16, r, e);
    model[3] = 15'h4444;
    xfer(mk_cmd(1'b1, 14'd2), 16, r, e);
    xfer(mk_cmd(1'b1, 14'd3), 16, r, e);
    check("R5 short abort discarded", r, 16'h2222);
    xfer(mk_cmd(1'b1, 14'd0), 16, r, e);
    check("R5 long abort discarded", r, 16'h4444);

    // R11: clock edges with select high
    sdi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sck = 1'b1; wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    check("R7 enable low while deselected", en, 0);
    sweep4("R11 idle clocks ignored");

    // R9: mode pin change ignored after reset
    mode = 1'b0;
    wait_clk(4);
    sweep4("R9 mode still 4-wire");

    // R10: software reset into 3-wire, registers cleared
    wr(14'h3FFF, 15'h2A55, 1'b1);
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    read3(14'd2, 16'h0000, 16'h0000);

    // R7: 3-wire write and read with a write command on the input during response
    xfer(mk_cmd(1'b0, 14'd3), 16, r, e);
    check("R7 write command enable low", e, 0);
    xfer(16'h0BCD, 16, r, e);
    check("R7 data frame enable low", e, 0);
    model[3] = 15'h0BCD;
    read3(14'd3, mk_cmd(1'b0, 14'd3), 16'h0BCD);
    read3(14'd3, 16'hFFFF, 16'h0BCD);
    xfer(mk_cmd(1'b1, 14'd4) ^ 16'h0001, 16, r, e);
    check("R7 errored command enable low", e, 0);
    xfer(16'h0000, 16, r, e);
    check("R4 3-wire error enable", e, 1);
    check("R4 3-wire error response", r, 16'h8000);

    // R9: mode pin high does not switch back by itself
    mode = 1'b1;
    wait_clk(4);
    xfer(mk_cmd(1'b0, 14'd5), 16, r, e);
    check("R9 still 3-wire", e, 0);
    xfer(16'h0055, 16, r, e);
    model[5] = 15'h0055;

    // R10: software reset back into 4-wire
    wr(14'h3FFF, 15'h2A55, 1'b0);
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    sweep4("R10 cleared, 4-wire again");

    // R1: power-on reset with mode pin low selects 3-wire
    mode = 1'b0;
    rst = 1'b1;
    wait_clk(6);
    rst = 1'b0;
    wait_clk(4);
    xfer(mk_cmd(1'b1, 14'd0), 16, r, e);
    check("R1 reset latches 3-wire", e, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule